// File: doc/BRIEF.md
# Dual-Clock Stream FIFO with Programmable Threshold Flag

This block is a 256-word by 18-bit first-in first-out buffer. A write clock and a read clock run it, and the two clocks may be unrelated or the same. Words enter on a valid/ready stream in the write domain. They leave on a valid/ready stream in the read domain. The read side works in fall-through mode: the oldest stored word always sits on the output, and the read side never has to fetch it first.

There are four status outputs. Full and empty are active low. Half-full is active high. A threshold flag is high when the FIFO is nearly empty or nearly full. It uses two 8-bit offsets: a low margin X and a high margin Y. After reset, if the active-low program input is low, the first one or two accepted writes load these offsets and do not store data. An offset that is never loaded stays at 32. The output enable is modelled as a drive signal and forces the data output to zero when it is off.

Back-pressure works the same way on both sides. A transfer happens on a rising edge of the side's own clock when valid and ready are both high. The write side holds in_ready low while the FIFO is full. The read side holds out_valid low while it is empty. A writer that offers data while in_ready is low must keep it stable until it is taken. The FIFO moves words across the clock domains as Gray-coded pointers through two-flop synchronizers. As a result, a flag computed in one domain can lag the other domain's activity by a few cycles. Every requirement below describes the flags once both sides have been idle long enough for the pointers to settle.

Top module: `dualclk_flag_fifo`

## Requirements
- R1: Words leave in the order they were accepted, bit for bit across all 18 bits, and up to 256 words can be held at once.
- R2: With 256 words held, full_n is low and in_ready is low. A write offered in that state is not taken and leaves the stored contents unchanged. With fewer words, full_n is high.
- R3: With no words held, empty_n and out_valid are both low. Raising out_ready in that state removes nothing, so the next word written is the next word read.
- R4: half_full is high when 128 or more words are held and low otherwise.
- R5: After reset, if prog_n is low on the first accepted write, in_data[7:0] becomes X. If prog_n is still low on the second accepted write, in_data[7:0] becomes Y. Neither of these writes is stored as data.
- R6: If prog_n is high on an accepted write before both offsets are loaded, programming ends and that write is stored as data. Any offset not loaded is 32.
- R7: af_ae is high when the count is at most X or at least 256 minus Y, and low otherwise.
- R8: While rst_n is low, both pointers clear, full_n is high, empty_n is low, half_full is low and out_valid is low.
- R9: The first word written into an empty FIFO appears on out_data with out_valid and empty_n high, and no read is needed. A read (out_valid and out_ready high at a read-clock rising edge) advances the output to the next word.
- R10: When oe_n is high, out_drive is low and out_data is all zeros. When oe_n is low, out_drive is high and out_data is a noninverted copy of the head word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, to both domains |
| prog_n | input | 1 | Offset programming enable, active low |
| in_valid | input | 1 | Write stream valid |
| in_ready | output | 1 | Write stream ready (not full) |
| in_data | input | 18 | Write stream data; bits 7:0 carry offsets while programming |
| out_valid | output | 1 | Read stream valid (head word present) |
| out_ready | input | 1 | Read stream ready |
| out_data | output | 18 | Head word, zero when output drive is off |
| oe_n | input | 1 | Output enable, active low |
| out_drive | output | 1 | High while the data output is driven |
| full_n | output | 1 | Low when 256 words are held (write domain) |
| empty_n | output | 1 | Low when no word is held (read domain) |
| half_full | output | 1 | High at 128 or more words (write domain) |
| af_ae | output | 1 | High near empty or near full, per X and Y (write domain) |

## Verification
The bench programs asymmetric offsets (X=5, Y=10). It then steps the count across every flag boundary: 5/6, 127/128, 245/246 and 255/256. A design with an off-by-one threshold, or with the two offsets swapped, would report the wrong flag at one of these steps. It also offers writes while full and reads while empty, then drains the FIFO or writes a marker word. A design that overwrote the oldest slot or moved a pointer on a refused transfer would deliver a wrong or out-of-order word. A second reset leaves prog_n high so that the first write is data and the offsets stay at 32. A design that swallowed that word or kept stale offsets would fail the check at count 32/33 or 223/224. A long random phase with independent stalls on both clocks catches pointer-crossing errors as lost or repeated words.

// File: rtl/ffp_pkg.sv
`timescale 1ns/1ps
package ffp_pkg;
  typedef enum logic [1:0] {
    PG_LOW_MARGIN  = 2'd0,
    PG_HIGH_MARGIN = 2'd1,
    PG_DONE        = 2'd2
  } prog_state_t;

  function automatic logic [15:0] bin_to_gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] gray_to_bin(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/ffp_sync.sv
`timescale 1ns/1ps
module ffp_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/ffp_mem.sv
`timescale 1ns/1ps
module ffp_mem #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/ffp_wr_side.sv
`timescale 1ns/1ps
module ffp_wr_side
  import ffp_pkg::*;
#(
  parameter int DW      = 18,
  parameter int AW      = 8,
  parameter int DEF_OFF = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [AW:0]   rgray_sync,
  output logic          in_ready,
  output logic          mem_we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW:0]   count,
  output logic          full_n,
  output logic          half_full,
  output logic          af_ae
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);
  localparam logic [PW-1:0] HALF_P  = PW'(1 << (AW - 1));
  localparam logic [AW-1:0] DEF_P   = AW'(DEF_OFF);

  logic [PW-1:0] wbin, wbin_nxt, rbin_sync, hi_thr;
  logic [AW-1:0] low_margin, high_margin;
  prog_state_t   pstate;
  logic          full, fire, prog_take;

  // Full: write pointer one lap ahead of the synchronized read pointer
  assign full      = (wgray == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
  assign in_ready  = ~full;
  assign fire      = in_valid & ~full;
  assign prog_take = fire & ~prog_n & (pstate != PG_DONE);
  assign mem_we    = fire & ~prog_take;
  assign wbin_nxt  = wbin + PW'(1);
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (mem_we) begin
      wbin  <= wbin_nxt;
      wgray <= PW'(bin_to_gray(16'(wbin_nxt)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate      <= PG_LOW_MARGIN;
      low_margin  <= DEF_P;
      high_margin <= DEF_P;
    end else if (fire && pstate != PG_DONE) begin
      if (prog_n) begin
        pstate <= PG_DONE;
      end else if (pstate == PG_LOW_MARGIN) begin
        low_margin <= in_data[AW-1:0];
        pstate     <= PG_HIGH_MARGIN;
      end else begin
        high_margin <= in_data[AW-1:0];
        pstate      <= PG_DONE;
      end
    end
  end

  assign rbin_sync = PW'(gray_to_bin(16'(rgray_sync)));
  assign count     = wbin - rbin_sync;
  assign hi_thr    = DEPTH_P - {1'b0, high_margin};
  assign full_n    = ~full;
  assign half_full = (count >= HALF_P);
  assign af_ae     = (count <= {1'b0, low_margin}) || (count >= hi_thr);
endmodule

// File: rtl/ffp_rd_side.sv
`timescale 1ns/1ps
module ffp_rd_side
  import ffp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_ready,
  input  logic [AW:0]   wgray_sync,
  output logic          out_valid,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nxt;
  logic          empty, take;

  assign empty     = (rgray == wgray_sync);
  assign out_valid = ~empty;
  assign take      = out_ready & ~empty;
  assign rbin_nxt  = rbin + PW'(1);
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (take) begin
      rbin  <= rbin_nxt;
      rgray <= PW'(bin_to_gray(16'(rbin_nxt)));
    end
  end
endmodule

// File: rtl/dualclk_flag_fifo.sv
`timescale 1ns/1ps
module dualclk_flag_fifo #(
  parameter int DW      = 18,
  parameter int AW      = 8,
  parameter int DEF_OFF = 32
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          prog_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          oe_n,
  output logic          out_drive,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_full,
  output logic          af_ae
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws, wr_count;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] head;
  logic          mem_we;

  ffp_wr_side #(.DW(DW), .AW(AW), .DEF_OFF(DEF_OFF)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .prog_n(prog_n), .in_valid(in_valid),
    .in_data(in_data), .rgray_sync(rgray_ws), .in_ready(in_ready),
    .mem_we(mem_we), .waddr(waddr), .wgray(wgray), .count(wr_count),
    .full_n(full_n), .half_full(half_full), .af_ae(af_ae)
  );

  ffp_rd_side #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .out_ready(out_ready),
    .wgray_sync(wgray_rs), .out_valid(out_valid), .raddr(raddr), .rgray(rgray)
  );

  ffp_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_rs));
  ffp_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_ws));

  ffp_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(in_data),
    .raddr(raddr), .rdata(head)
  );

  assign empty_n   = out_valid;
  assign out_drive = ~oe_n;
  assign out_data  = oe_n ? '0 : head;
endmodule

// File: rtl/ffp_checker.sv
`timescale 1ns/1ps
module ffp_checker #(
  parameter int AW = 8
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic        full_n,
  input logic        empty_n,
  input logic        half_full,
  input logic [AW:0] wr_count
);
  localparam logic [AW:0] DEPTH_P = (AW+1)'(1 << AW);

  assert_no_overflow_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_count <= DEPTH_P);

  assert_full_needs_write_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $fell(full_n) |-> $past(in_valid && in_ready));

  assert_half_needs_write_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $rose(half_full) |-> $past(in_valid && in_ready));

  assert_empty_needs_read_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $fell(empty_n) |-> $past(out_valid && out_ready));

  always_comb begin
    if (!rst_n) begin
      assert_reset_flags_R8: assert (full_n && !empty_n && !half_full && !out_valid);
    end
  end
endmodule

bind dualclk_flag_fifo ffp_checker #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .full_n(full_n), .empty_n(empty_n), .half_full(half_full), .wr_count(wr_count)
);

// File: tb/sim_dualclk_flag_fifo.sv
`timescale 1ns/1ps
module sim_dualclk_flag_fifo;
  logic wr_clk = 0, rd_clk = 0, rst_n = 0, prog_n = 1;
  logic in_valid = 0, out_ready = 0, oe_n = 0;
  logic [17:0] in_data = '0;
  logic in_ready, out_valid, out_drive, full_n, empty_n, half_full, af_ae;
  logic [17:0] out_data;

  int compared = 0, mismatched = 0;
  int xoff = 32, yoff = 32;
  logic [17:0] model[$];

  always #10 wr_clk = ~wr_clk;
  always #13 rd_clk = ~rd_clk;

  dualclk_flag_fifo u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .prog_n(prog_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .oe_n(oe_n), .out_drive(out_drive), .full_n(full_n), .empty_n(empty_n),
    .half_full(half_full), .af_ae(af_ae)
  );

  function automatic bit exp_af(input int cnt, input int x, input int y);
    return (cnt <= x) || (cnt >= 256 - y);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge wr_clk);
    repeat (6) @(posedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic check_flags();
    int c = model.size();
    chk(full_n == (c != 256), "R2", "full_n", full_n, c != 256);
    chk(empty_n == (c != 0), "R3", "empty_n", empty_n, c != 0);
    chk(half_full == (c >= 128), "R4", "half_full", half_full, c >= 128);
    chk(af_ae == exp_af(c, xoff, yoff), "R7", "af_ae", af_ae, exp_af(c, xoff, yoff));
  endtask

  task automatic wr_word(input logic [17:0] d, input bit is_prog);
    @(negedge wr_clk);
    in_valid = 1; in_data = d;
    while (!in_ready) @(negedge wr_clk);
    if (!is_prog) model.push_back(d);
    @(posedge wr_clk);
    #1 in_valid = 0;
  endtask

  task automatic rd_word(input string req);
    @(negedge rd_clk);
    out_ready = 1;
    while (!out_valid) @(negedge rd_clk);
    chk(out_data == model[0], req, "read word", out_data, model[0]);
    void'(model.pop_front());
    @(posedge rd_clk);
    #1 out_ready = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge wr_clk);
    chk(full_n === 1'b1, "R8", "reset full_n", full_n, 1);
    chk(empty_n === 1'b0, "R8", "reset empty_n", empty_n, 0);
    chk(half_full === 1'b0, "R8", "reset half_full", half_full, 0);
    chk(out_valid === 1'b0, "R8", "reset out_valid", out_valid, 0);
    model.delete();
    rst_n = 1;
    repeat (3) @(negedge wr_clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(20 * 190000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // Phase 1: program X=5, Y=10
    do_reset();
    prog_n = 0;
    wr_word(18'h3FF05, 1'b1);
    wr_word(18'h2000A, 1'b1);
    prog_n = 1;
    xoff = 5; yoff = 10;
    settle();
    chk(empty_n == 0, "R5", "programming writes stored", empty_n, 0);
    // R9 fall-through of first word
    wr_word(18'h2A5C3, 1'b0);
    settle();
    chk(out_valid == 1, "R9", "out_valid without read", out_valid, 1);
    chk(out_data == 18'h2A5C3, "R9", "head word", out_data, 18'h2A5C3);
    check_flags();
    // R10 output enable
    oe_n = 1; #1;
    chk(out_data == 0, "R10", "data when disabled", out_data, 0);
    chk(out_drive == 0, "R10", "drive when disabled", out_drive, 0);
    oe_n = 0; #1;
    chk(out_drive == 1, "R10", "drive when enabled", out_drive, 1);
    chk(out_data == 18'h2A5C3, "R10", "noninverted data", out_data, 18'h2A5C3);
    // Fill across boundaries
    for (int c = 2; c <= 256; c++) begin
      wr_word(18'(c * 1031 + 7), 1'b0);
      if (c == 5 || c == 6 || c == 127 || c == 128 || c == 245 || c == 246 ||
          c == 255 || c == 256) begin
        settle();
        check_flags();
      end
    end
    chk(in_ready == 0, "R2", "in_ready when full", in_ready, 0);
    // Offer writes while full
    @(negedge wr_clk);
    in_valid = 1; in_data = 18'h3FFFF;
    repeat (6) @(negedge wr_clk);
    in_valid = 0;
    chk(full_n == 0, "R2", "still full after refused writes", full_n, 0);
    // Drain in order
    for (int i = 0; i < 256; i++) rd_word("R1");
    settle();
    check_flags();
    // Read attempts while empty
    @(negedge rd_clk);
    out_ready = 1;
    repeat (6) @(negedge rd_clk);
    out_ready = 0;
    wr_word(18'h1B0B0, 1'b0);
    settle();
    chk(out_data == 18'h1B0B0, "R3", "word after empty reads", out_data, 18'h1B0B0);
    rd_word("R9");

    // Phase 2: no programming, defaults
    do_reset();
    prog_n = 1;
    xoff = 32; yoff = 32;
    wr_word(18'h00011, 1'b0);
    settle();
    chk(out_data == 18'h00011, "R6", "first write stored as data", out_data, 18'h00011);
    for (int c = 2; c <= 224; c++) begin
      wr_word(18'(c * 77), 1'b0);
      if (c == 32 || c == 33 || c == 223 || c == 224) begin
        settle();
        chk(af_ae == exp_af(c, 32, 32), "R6", "af_ae default offsets", af_ae,
            exp_af(c, 32, 32));
      end
    end
    while (model.size() > 0) rd_word("R1");
    settle();

    // Phase 3: random traffic on both clocks
    fork
      begin
        int sent = 0;
        while (sent < 1500) begin
          @(negedge wr_clk);
          in_valid = ($urandom % 4) != 0;
          in_data  = 18'($urandom);
          if (in_valid && in_ready) begin
            model.push_back(in_data);
            sent++;
          end
        end
        @(negedge wr_clk);
        in_valid = 0;
      end
      begin
        int got = 0;
        while (got < 1500) begin
          @(negedge rd_clk);
          out_ready = ($urandom % 3) != 0;
          if (out_ready && out_valid) begin
            chk(out_data == model[0], "R1", "random read", out_data, model[0]);
            void'(model.pop_front());
            got++;
          end
        end
        @(negedge rd_clk);
        out_ready = 0;
      end
    join
    settle();
    check_flags();
    summary();
    $finish;
  end
endmodule